// File: doc/BRIEF.md
# Serial ATA Device Link Bring-Up Sequencer

This block is the device-side control loop that takes a serial ATA link from reset to normal operation. It watches the events that the out-of-band detectors report: a host reset pattern seen, the release of that pattern, and a wake pattern from the host. It also watches two primitive flags from the receive path: ALIGN seen, and some other primitive seen. From these it drives the PHY sideband requests: send an init burst, send wake bursts, stream ALIGN at a chosen speed, and stream SYNC. It reports either link-up or failure.

After the host releases its reset pattern, or whenever the device asks for it, the sequencer sends one init request and then waits for the host wake. It answers with six wake burst requests and then streams ALIGN, starting at the fastest supported speed. Each speed has a fixed window in which the host must return ALIGN. When the window runs out, the sequencer moves to the next slower supported speed. When the slowest speed also runs out, it stops in a failure state. Once host ALIGN arrives, it streams SYNC. The link is declared up after three consecutive primitives that are not ALIGN.

Top module: `link_bringup_seq`

## Requirements
- R1: Right after reset, all of tx_cominit, tx_comwake, tx_align, tx_sync, link_up and link_err are low, and speed_sel holds the fastest supported speed. speed_sel is a speed index: bit i of SPEED_MASK set means speed i is supported, and a larger index is a faster speed.
- R2: A pulse on rx_reset_rel while waiting for reset, or a pulse on dev_init_req in any state except failure, makes tx_cominit high for exactly one cycle, starting in the following cycle.
- R3: After the init request, rx_wake_det sets tx_comwake high for exactly WAKE_BURSTS (6) consecutive cycles. tx_align then rises together with speed_sel set to the fastest supported speed. Before rx_wake_det arrives, tx_comwake stays low.
- R4: While ALIGN is streamed with no rx_align, each speed lasts exactly ALIGN_TIMEOUT cycles. speed_sel then moves to the next slower speed whose mask bit is set, and speeds whose mask bit is clear are skipped.
- R5: When the slowest supported speed times out, tx_align falls and link_err rises in the next cycle.
- R6: rx_align during ALIGN streaming switches the output to tx_sync in the following cycle, with speed_sel unchanged. If rx_align and a timeout fall in the same cycle, rx_align wins.
- R7: While SYNC is streamed, link_up rises in the cycle after the third consecutive rx_nonalign. Any rx_align restarts the count from zero, and it takes priority when both flags are high together.
- R8: rx_reset_det in any state returns the block to reset wait in the next cycle, with all request and status outputs low. In reset wait, rx_wake_det has no effect.
- R9: link_err holds until rx_reset_det or restart. In the failure state rx_wake_det, rx_align and dev_init_req have no effect. restart produces a one-cycle tx_cominit.
- R10: At most one of tx_cominit, tx_comwake, tx_align, tx_sync, link_up and link_err is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_reset_det | input | 1 | Host reset pattern detected |
| rx_reset_rel | input | 1 | Host reset pattern released |
| rx_wake_det | input | 1 | Host wake pattern detected |
| rx_align | input | 1 | ALIGN primitive received |
| rx_nonalign | input | 1 | Primitive other than ALIGN received |
| dev_init_req | input | 1 | Device-initiated bring-up request |
| restart | input | 1 | Leave the failure state and start again |
| tx_cominit | output | 1 | Request one init burst from the PHY |
| tx_comwake | output | 1 | Request one wake burst per cycle high |
| tx_align | output | 1 | Stream ALIGN primitives |
| tx_sync | output | 1 | Stream SYNC primitives |
| speed_sel | output | $clog2(NUM_SPEEDS) | Speed index for the transmitter |
| link_up | output | 1 | Link established |
| link_err | output | 1 | All supported speeds failed |

## Verification
The bench picks the cycle of host ALIGN arrival at random across both speed windows, including the last cycle of each window. A timer that is off by one, or that does not restart on a speed drop, reports the wrong speed there. The speed mask leaves out the middle speed, so a sequencer that steps down by one index would stream at a speed the PHY does not support. The SYNC phase gets random runs of ALIGN and non-ALIGN flags. A run count that does not clear on ALIGN, or a threshold that is off by one, raises link_up in the wrong cycle. Wake, ALIGN and device requests are sent during the failure state and during reset wait, and a design that lets them through would leave failure or start sending bursts.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [2:0] {
    ST_RST_WAIT,
    ST_INIT_TX,
    ST_WAKE_WAIT,
    ST_WAKE_TX,
    ST_ALIGN_TX,
    ST_SYNC_TX,
    ST_LINKED,
    ST_FAIL
  } lbs_state_e;

  // Index of the highest set bit of a speed mask (0 when empty).
  function automatic int top_of(input logic [31:0] m);
    int r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (m[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/lbs_cycle_cnt.sv
module lbs_cycle_cnt #(
  parameter int LIMIT = 6,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic last
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign last = en && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!en || last) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/lbs_run_cnt.sv
module lbs_run_cnt #(
  parameter int RUN = 3,
  localparam int RW = $clog2(RUN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic rx_align,
  input  logic rx_nonalign,
  output logic hit
);

  logic [RW-1:0] run_q;
  logic [RW-1:0] run_d;

  assign hit = active && rx_nonalign && !rx_align && (run_q == RW'(RUN - 1));

  always_comb begin
    run_d = run_q;
    if (!active || rx_align)     run_d = '0;
    else if (hit)                run_d = '0;
    else if (rx_nonalign)        run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

endmodule

// File: rtl/lbs_speed_pick.sv
module lbs_speed_pick #(
  parameter int NUM_SPEEDS = 3,
  parameter logic [NUM_SPEEDS-1:0] SPEED_MASK = '1,
  localparam int SPW = $clog2(NUM_SPEEDS)
) (
  input  logic [SPW-1:0] cur,
  output logic [SPW-1:0] lower,
  output logic           has_lower
);

  logic [NUM_SPEEDS-1:0] below;

  // One candidate flag per speed: supported and slower than the current one.
  for (genvar g = 0; g < NUM_SPEEDS; g++) begin : g_cand
    assign below[g] = SPEED_MASK[g] && (SPW'(g) < cur);
  end

  always_comb begin
    lower     = '0;
    has_lower = 1'b0;
    for (int i = 0; i < NUM_SPEEDS; i++) begin
      if (below[i]) begin
        lower     = SPW'(i);
        has_lower = 1'b1;
      end
    end
  end

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq #(
  parameter int NUM_SPEEDS    = 3,
  parameter logic [NUM_SPEEDS-1:0] SPEED_MASK = '1,
  parameter int ALIGN_TIMEOUT = 2048,
  parameter int WAKE_BURSTS   = 6,
  parameter int NONALIGN_RUN  = 3,
  localparam int SPW = $clog2(NUM_SPEEDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_reset_det,
  input  logic           rx_reset_rel,
  input  logic           rx_wake_det,
  input  logic           rx_align,
  input  logic           rx_nonalign,
  input  logic           dev_init_req,
  input  logic           restart,
  output logic           tx_cominit,
  output logic           tx_comwake,
  output logic           tx_align,
  output logic           tx_sync,
  output logic [SPW-1:0] speed_sel,
  output logic           link_up,
  output logic           link_err
);
  import lbs_pkg::*;

  localparam logic [SPW-1:0] TOP_IDX = SPW'(top_of(32'(SPEED_MASK)));

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  lbs_state_e       st_q, st_d;
  logic [SPW-1:0]   spd_q, spd_d;
  logic             wake_last, tmo_last, run_hit;
  logic [SPW-1:0]   spd_lower;
  logic             spd_has_lower;

  lbs_cycle_cnt #(.LIMIT(WAKE_BURSTS)) u_wake_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (st_q == ST_WAKE_TX),
    .last  (wake_last)
  );

  lbs_cycle_cnt #(.LIMIT(ALIGN_TIMEOUT)) u_align_tmr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (st_q == ST_ALIGN_TX),
    .last  (tmo_last)
  );

  lbs_run_cnt #(.RUN(NONALIGN_RUN)) u_run (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .active      (st_q == ST_SYNC_TX),
    .rx_align    (rx_align),
    .rx_nonalign (rx_nonalign),
    .hit         (run_hit)
  );

  lbs_speed_pick #(.NUM_SPEEDS(NUM_SPEEDS), .SPEED_MASK(SPEED_MASK)) u_pick (
    .cur       (spd_q),
    .lower     (spd_lower),
    .has_lower (spd_has_lower)
  );

  always_comb begin
    st_d  = st_q;
    spd_d = spd_q;
    if (rx_reset_det) begin
      st_d = ST_RST_WAIT;
    end else begin
      unique case (st_q)
        ST_RST_WAIT:  if (rx_reset_rel || dev_init_req) st_d = ST_INIT_TX;
        ST_INIT_TX:   st_d = ST_WAKE_WAIT;
        ST_WAKE_WAIT: begin
          if (dev_init_req)     st_d = ST_INIT_TX;
          else if (rx_wake_det) st_d = ST_WAKE_TX;
        end
        ST_WAKE_TX: begin
          if (dev_init_req) st_d = ST_INIT_TX;
          else if (wake_last) begin
            st_d  = ST_ALIGN_TX;
            spd_d = TOP_IDX;
          end
        end
        ST_ALIGN_TX: begin
          if (dev_init_req)  st_d = ST_INIT_TX;
          else if (rx_align) st_d = ST_SYNC_TX;
          else if (tmo_last) begin
            if (spd_has_lower) spd_d = spd_lower;
            else               st_d  = ST_FAIL;
          end
        end
        ST_SYNC_TX: begin
          if (dev_init_req) st_d = ST_INIT_TX;
          else if (run_hit) st_d = ST_LINKED;
        end
        ST_LINKED:    if (dev_init_req) st_d = ST_INIT_TX;
        ST_FAIL:      if (restart) st_d = ST_INIT_TX;
        default:      st_d = ST_RST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q  <= ST_RST_WAIT;
      spd_q <= TOP_IDX;
    end else begin
      st_q  <= st_d;
      spd_q <= spd_d;
    end
  end

  assign tx_cominit = (st_q == ST_INIT_TX);
  assign tx_comwake = (st_q == ST_WAKE_TX);
  assign tx_align   = (st_q == ST_ALIGN_TX);
  assign tx_sync    = (st_q == ST_SYNC_TX);
  assign link_up    = (st_q == ST_LINKED);
  assign link_err   = (st_q == ST_FAIL);
  assign speed_sel  = spd_q;

endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
  parameter int NUM_SPEEDS = 3,
  parameter logic [NUM_SPEEDS-1:0] SPEED_MASK = '1,
  localparam int SPW = $clog2(NUM_SPEEDS)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rx_reset_det,
  input logic           rx_align,
  input logic           restart,
  input logic           tx_cominit,
  input logic           tx_comwake,
  input logic           tx_align,
  input logic           tx_sync,
  input logic [SPW-1:0] speed_sel,
  input logic           link_up,
  input logic           link_err
);

  logic [NUM_SPEEDS-1:0] mask_sh;
  assign mask_sh = SPEED_MASK >> speed_sel;

  AST_COMINIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cominit |=> !tx_cominit); // R2

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset_det |=> !(tx_cominit || tx_comwake || tx_align || tx_sync || link_up || link_err)); // R8

  AST_SPEED_ONLY_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_align && $past(tx_align) && speed_sel != $past(speed_sel)) |-> (speed_sel < $past(speed_sel))); // R4

  AST_SPEED_SUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_align |-> mask_sh[0]); // R4

  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (link_err && !rx_reset_det && !restart) |=> link_err); // R9

  AST_SYNC_NEEDS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_sync) |-> ($past(rx_align) && $past(tx_align))); // R6

  AST_LINK_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> $past(tx_sync)); // R7

  AST_ERR_FROM_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_err) |-> $past(tx_align)); // R5

  AST_OUTPUTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_cominit, tx_comwake, tx_align, tx_sync, link_up, link_err})); // R10

endmodule

bind link_bringup_seq lbs_checker #(
  .NUM_SPEEDS (NUM_SPEEDS),
  .SPEED_MASK (SPEED_MASK)
) u_lbs_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_reset_det (rx_reset_det),
  .rx_align     (rx_align),
  .restart      (restart),
  .tx_cominit   (tx_cominit),
  .tx_comwake   (tx_comwake),
  .tx_align     (tx_align),
  .tx_sync      (tx_sync),
  .speed_sel    (speed_sel),
  .link_up      (link_up),
  .link_err     (link_err)
);

// File: tb/link_bringup_seq_test.sv
module link_bringup_seq_test;

  localparam int NS   = 3;
  localparam logic [NS-1:0] MASK = 3'b101;
  localparam int TMO  = 40;
  localparam int WB   = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_reset_det, rx_reset_rel, rx_wake_det, rx_align, rx_nonalign, dev_init_req, restart;
  logic tx_cominit, tx_comwake, tx_align, tx_sync, link_up, link_err;
  logic [1:0] speed_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  link_bringup_seq #(
    .NUM_SPEEDS(NS), .SPEED_MASK(MASK), .ALIGN_TIMEOUT(TMO),
    .WAKE_BURSTS(WB), .NONALIGN_RUN(3)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .rx_reset_det(rx_reset_det), .rx_reset_rel(rx_reset_rel), .rx_wake_det(rx_wake_det),
    .rx_align(rx_align), .rx_nonalign(rx_nonalign), .dev_init_req(dev_init_req),
    .restart(restart),
    .tx_cominit(tx_cominit), .tx_comwake(tx_comwake), .tx_align(tx_align),
    .tx_sync(tx_sync), .speed_sel(speed_sel), .link_up(link_up), .link_err(link_err)
  );

  function automatic int top_spd();
    int r = 0;
    for (int i = 0; i < NS; i++) if (MASK[i]) r = i;
    return r;
  endfunction

  function automatic int next_lower(input int s);
    int r = -1;
    for (int i = 0; i < NS; i++) if (MASK[i] && i < s) r = i;
    return r;
  endfunction

  // Speed expected at ALIGN sample index t (index 0 = first ALIGN cycle).
  function automatic int exp_speed(input int t);
    int s = top_spd();
    for (int k = 0; k < t / TMO; k++) s = next_lower(s);
    return s;
  endfunction

  function automatic int outs();
    return {26'd0, tx_cominit, tx_comwake, tx_align, tx_sync, link_up, link_err};
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // From the wake-wait state: wake pulse, count bursts, land on ALIGN index 0.
  task automatic wake_to_align();
    int cnt = 0;
    rx_wake_det = 1'b1; tick(); rx_wake_det = 1'b0;
    while (tx_comwake && cnt < 100) begin cnt++; tick(); end
    check("R3 wake burst cycles", cnt, WB);
    check("R3 align after wake", tx_align, 1);
    check("R3 start speed", speed_sel, top_spd());
  endtask

  task automatic release_to_wait();
    rx_reset_rel = 1'b1; tick(); rx_reset_rel = 1'b0;
    check("R2 cominit after release", tx_cominit, 1);
    tick();
    check("R2 cominit one cycle", tx_cominit, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5a7a_1234);
    rst_n = 1'b0;
    {rx_reset_det, rx_reset_rel, rx_wake_det, rx_align, rx_nonalign, dev_init_req, restart} = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    check("R1 outputs after reset", outs(), 0);
    check("R1 speed after reset", speed_sel, top_spd());

    // R8: wake ignored while waiting for reset release
    rx_wake_det = 1'b1; tick(); rx_wake_det = 1'b0; tick();
    check("R8 wake ignored in reset wait", outs(), 0);

    release_to_wait();

    // Random trials: ALIGN arrival anywhere in both windows, random SYNC traffic.
    for (int trial = 0; trial < 8; trial++) begin
      int t;
      int run;
      int steps;
      int idle = $urandom_range(1, 15);
      for (int k = 0; k < idle; k++) tick();
      check("R3 no wake bursts before host wake", tx_comwake, 0);
      wake_to_align();
      case (trial)
        0: t = 0;
        1: t = TMO - 1;
        2: t = TMO;
        3: t = 2 * TMO - 1;
        default: t = $urandom_range(0, 2 * TMO - 1);
      endcase
      for (int k = 0; k < t; k++) tick();
      check("R4 speed in window", speed_sel, exp_speed(t));
      check("R4 still aligning", tx_align, 1);
      rx_align = 1'b1; tick(); rx_align = 1'b0;
      check("R6 sync after host align", tx_sync, 1);
      check("R6 speed kept", speed_sel, exp_speed(t));
      run = 0; steps = 0;
      while (run < 3 && steps < 300) begin
        int sym = $urandom_range(0, 3);
        rx_align    = (sym == 1) || (sym == 3);
        rx_nonalign = (sym >= 2);
        if (rx_align) run = 0;
        else if (rx_nonalign) run++;
        tick();
        rx_align = 1'b0; rx_nonalign = 1'b0;
        steps++;
        check("R7 link_up vs run", link_up, (run >= 3) ? 1 : 0);
        check("R10 exclusive outputs", $countones(outs()) <= 1, 1);
      end
      rx_reset_det = 1'b1; tick(); rx_reset_det = 1'b0;
      check("R8 reset from linked", outs(), 0);
      release_to_wait();
    end

    // Full fallback: 2 -> 0 (1 skipped) -> failure.
    wake_to_align();
    for (int k = 0; k < TMO - 1; k++) tick();
    check("R4 last cycle at top speed", speed_sel, 2);
    tick();
    check("R4 skip unsupported speed", speed_sel, 0);
    check("R4 align continues", tx_align, 1);
    for (int k = 0; k < TMO - 1; k++) tick();
    check("R5 not yet failed", link_err, 0);
    tick();
    check("R5 failure after slowest", link_err, 1);
    check("R5 align stopped", tx_align, 0);

    // R9: failure ignores wake, align and device requests.
    rx_wake_det = 1'b1; tick(); rx_wake_det = 1'b0;
    rx_align = 1'b1; tick(); rx_align = 1'b0;
    dev_init_req = 1'b1; tick(); dev_init_req = 1'b0;
    repeat (3) tick();
    check("R9 failure holds", outs(), 1);
    restart = 1'b1; tick(); restart = 1'b0;
    check("R9 restart gives cominit", tx_cominit, 1);
    tick();

    // R7 directed: N N A N N -> not up, then N -> up.
    wake_to_align();
    rx_align = 1'b1; tick(); rx_align = 1'b0;
    for (int k = 0; k < 5; k++) begin
      rx_nonalign = (k != 2); rx_align = (k == 2);
      tick();
      rx_nonalign = 1'b0; rx_align = 1'b0;
    end
    check("R7 run broken by align", link_up, 0);
    rx_nonalign = 1'b1; tick(); rx_nonalign = 1'b0;
    check("R7 link after third in a row", link_up, 1);

    // R2: device request from linked state.
    dev_init_req = 1'b1; tick(); dev_init_req = 1'b0;
    check("R2 device request cominit", tx_cominit, 1);
    check("R2 link dropped", link_up, 0);
    tick();

    // R8: reset pattern mid-ALIGN, then device request from reset wait.
    wake_to_align();
    repeat (5) tick();
    rx_reset_det = 1'b1; tick(); rx_reset_det = 1'b0;
    check("R8 reset from align", outs(), 0);
    dev_init_req = 1'b1; tick(); dev_init_req = 1'b0;
    check("R2 device request from reset wait", tx_cominit, 1);

    finish_run();
  end

endmodule